// File: doc/BRIEF.md
# Grouped GPIO Bank with Output Enables

This block is a general-purpose I/O controller whose pins are split into groups of eight lanes. Pin `n` belongs to group `n/8` and occupies lane `n mod 8` of every per-group register. Direction and pin-mode control live in a byte-indexed configuration space. The pin data lives in a separate byte-addressed I/O window. The window starts at a base address that is held in two configuration registers and can be moved at run time.

Each group has an output-enable byte. Only the leading `MODE_GROUPS` groups also have a mode byte, which hands a pin from its alternate function over to plain I/O. Pins in the other groups are always plain I/O. A pin drives its output latch only when its output enable is set and it is in plain-I/O mode. Otherwise it stays released. A data write replaces all eight latches of a group at once, so changing a single pin takes a read-modify-write. A data read returns the pad levels after a two-flop synchroniser, not the latch contents. Addresses outside the window read as all ones and ignore writes.

Top module: `gpio_group_bank`

## Requirements
- R1: After reset, every output-enable bit, mode bit and output latch is 0, the window base is 0x0000, and `pad_oe` and `pad_out` are all zero.
- R2: Pin `n` is controlled by bit `n mod 8` of the byte that belongs to group `n/8`, in both the configuration and the data registers.
- R3: The output-enable byte of group `g` sits at configuration index 0xC8+g. A 1 bit makes the pin an output, a 0 makes it an input, and the byte reads back what was written.
- R4: The mode byte of group `g` sits at index 0xC0+g only for `g < MODE_GROUPS`. A 1 bit selects plain I/O. For higher groups, those indices read 0x00 and ignore writes, and the pins are always plain I/O (`gpio_sel` = 1).
- R5: `pad_oe[n]` is 1 exactly when the output enable is set and the pin is in plain-I/O mode. `pad_out[n]` equals the latch bit while `pad_oe[n]` is 1, and 0 otherwise.
- R6: A data write to address base+g, with g below `NUM_GROUPS`, replaces all eight latches of group g with the write byte in the same clock edge.
- R7: A data read at base+g returns the pad levels of group g as they were two clock edges earlier, including for pins that are driven as outputs.
- R8: A data address outside base .. base+NUM_GROUPS-1, computed modulo 2^16, reads 0xFF, and a write there leaves every latch unchanged.
- R9: Configuration index 0x60 holds the high byte and index 0x61 the low byte of the data window base. Both read back, and a new base moves the window from the next cycle on.
- R10: Any configuration index not listed in R3, R4 or R9 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte (combinational) |
| io_we | input | 1 | Data-window write strobe |
| io_addr | input | 16 | Data-window byte address |
| io_wdata | input | 8 | Data write byte |
| io_rdata | output | 8 | Data read byte (combinational) |
| pad_in | input | NUM_GROUPS*8 | Pad levels from the pins |
| pad_out | output | NUM_GROUPS*8 | Value driven onto each pin |
| pad_oe | output | NUM_GROUPS*8 | Per-pin driver enable |
| gpio_sel | output | NUM_GROUPS*8 | 1 where the pin belongs to plain I/O rather than its alternate function |

## Verification
Random traffic mixes configuration writes to the enable, mode, base and unmapped indices with data writes that land inside or just beyond the window. It also moves the pad levels. After each operation the bench compares every pad enable and driven value against its own model, which tells a wrong mode gate apart from a wrong enable lane. Directed cases are also run:
- a single pin routed through one lane, which separates the group and bit mapping;
- an enable in a group with no mode byte;
- a whole-byte write that overwrites an earlier pattern;
- a pad change read one and two edges later, which pins down the synchroniser depth;
- a window relocation followed by accesses on both sides of the window edges.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  localparam int unsigned LANE_W = 8;
  localparam logic [7:0] OE_IDX0     = 8'hC8;
  localparam logic [7:0] MODE_IDX0   = 8'hC0;
  localparam logic [7:0] BASE_HI_IDX = 8'h60;
  localparam logic [7:0] BASE_LO_IDX = 8'h61;

  function automatic int unsigned pin_group(input int unsigned n);
    return n / LANE_W;
  endfunction

  function automatic int unsigned pin_lane(input int unsigned n);
    return n % LANE_W;
  endfunction

  // Driver enable: output enable gated by plain-I/O mode when the group has a mode byte
  function automatic logic drive_enable(input logic oe, input logic has_mode, input logic mode);
    return oe & (~has_mode | mode);
  endfunction

  // Window offset, modulo 2^16
  function automatic logic [15:0] window_offset(input logic [15:0] addr, input logic [15:0] base);
    return addr - base;
  endfunction
endpackage

// File: rtl/gpio_grp_cfg.sv
module gpio_grp_cfg
  import gpio_grp_pkg::*;
#(
  parameter int unsigned NUM_GROUPS  = 8,
  parameter int unsigned MODE_GROUPS = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [7:0]                   cfg_idx,
  input  logic [7:0]                   cfg_wdata,
  output logic [7:0]                   cfg_rdata,
  output logic [NUM_GROUPS*LANE_W-1:0] oe_bits,
  output logic [NUM_GROUPS*LANE_W-1:0] mode_bits,
  output logic [15:0]                  io_base
);
  logic [7:0] oe_q   [NUM_GROUPS];
  logic [7:0] mode_q [NUM_GROUPS];
  logic [7:0] base_hi_q, base_lo_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    oe_q[g] <= '0;
      else if (cfg_we && cfg_idx == OE_IDX0 + 8'(g)) oe_q[g] <= cfg_wdata;
    end
    assign oe_bits[g*LANE_W +: LANE_W] = oe_q[g];

    if (g < MODE_GROUPS) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      mode_q[g] <= '0;
        else if (cfg_we && cfg_idx == MODE_IDX0 + 8'(g)) mode_q[g] <= cfg_wdata;
      end
    end else begin : g_fixed
      assign mode_q[g] = '0;
    end
    assign mode_bits[g*LANE_W +: LANE_W] = mode_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi_q <= '0;
      base_lo_q <= '0;
    end else if (cfg_we) begin
      if (cfg_idx == BASE_HI_IDX) base_hi_q <= cfg_wdata;
      if (cfg_idx == BASE_LO_IDX) base_lo_q <= cfg_wdata;
    end
  end
  assign io_base = {base_hi_q, base_lo_q};

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_idx == BASE_HI_IDX) cfg_rdata = base_hi_q;
    if (cfg_idx == BASE_LO_IDX) cfg_rdata = base_lo_q;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (cfg_idx == OE_IDX0 + 8'(g)) cfg_rdata = oe_q[g];
      if (g < MODE_GROUPS && cfg_idx == MODE_IDX0 + 8'(g)) cfg_rdata = mode_q[g];
    end
  end
endmodule

// File: rtl/gpio_grp_data.sv
module gpio_grp_data
  import gpio_grp_pkg::*;
#(
  parameter int unsigned NUM_GROUPS  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPINS = NUM_GROUPS * LANE_W,
  localparam int unsigned GRP_W = $clog2(NUM_GROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      io_base,
  input  logic             io_we,
  input  logic [15:0]      io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] latch_bits,
  output logic [NPINS-1:0] sync_lvl,
  output logic             data_hit,
  output logic [GRP_W-1:0] data_grp
);
  logic [NPINS-1:0] stg [SYNC_STAGES];
  logic [15:0]      offset;
  logic [7:0]       lat_q [NUM_GROUPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= pad_in;
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end
  assign sync_lvl = stg[SYNC_STAGES-1];

  assign offset   = window_offset(io_addr, io_base);
  assign data_hit = offset < 16'(NUM_GROUPS);
  assign data_grp = offset[GRP_W-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          lat_q[g] <= '0;
      else if (io_we && data_hit && data_grp == GRP_W'(g)) lat_q[g] <= io_wdata;
    end
    assign latch_bits[g*LANE_W +: LANE_W] = lat_q[g];
  end

  assign io_rdata = data_hit ? sync_lvl[data_grp*LANE_W +: LANE_W] : 8'hFF;
endmodule

// File: rtl/gpio_grp_pad.sv
module gpio_grp_pad
  import gpio_grp_pkg::*;
#(
  parameter int unsigned NUM_GROUPS  = 8,
  parameter int unsigned MODE_GROUPS = 5,
  localparam int unsigned NPINS = NUM_GROUPS * LANE_W
) (
  input  logic [NPINS-1:0] oe_bits,
  input  logic [NPINS-1:0] mode_bits,
  input  logic [NPINS-1:0] latch_bits,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] gpio_sel
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    localparam int unsigned GRP = pin_group(n);
    localparam int unsigned LN  = pin_lane(n);
    localparam logic HAS_MODE   = GRP < MODE_GROUPS;
    logic en;
    assign en          = drive_enable(oe_bits[GRP*LANE_W+LN], HAS_MODE, mode_bits[GRP*LANE_W+LN]);
    assign pad_oe[n]   = en;
    assign pad_out[n]  = en & latch_bits[GRP*LANE_W+LN];
    assign gpio_sel[n] = HAS_MODE ? mode_bits[GRP*LANE_W+LN] : 1'b1;
  end
endmodule

// File: rtl/gpio_group_bank.sv
module gpio_group_bank
  import gpio_grp_pkg::*;
#(
  parameter int unsigned NUM_GROUPS  = 8,
  parameter int unsigned MODE_GROUPS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [7:0]               cfg_idx,
  input  logic [7:0]               cfg_wdata,
  output logic [7:0]               cfg_rdata,
  input  logic                     io_we,
  input  logic [15:0]              io_addr,
  input  logic [7:0]               io_wdata,
  output logic [7:0]               io_rdata,
  input  logic [NUM_GROUPS*8-1:0]  pad_in,
  output logic [NUM_GROUPS*8-1:0]  pad_out,
  output logic [NUM_GROUPS*8-1:0]  pad_oe,
  output logic [NUM_GROUPS*8-1:0]  gpio_sel
);
  localparam int unsigned NPINS = NUM_GROUPS * LANE_W;
  localparam int unsigned GRP_W = $clog2(NUM_GROUPS);

  logic [NPINS-1:0] oe_bits, mode_bits, latch_bits, sync_lvl;
  logic [15:0]      io_base;
  logic             data_hit;
  logic [GRP_W-1:0] data_grp;

  gpio_grp_cfg #(.NUM_GROUPS(NUM_GROUPS), .MODE_GROUPS(MODE_GROUPS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .oe_bits(oe_bits), .mode_bits(mode_bits), .io_base(io_base)
  );

  gpio_grp_data #(.NUM_GROUPS(NUM_GROUPS), .SYNC_STAGES(2)) u_data (
    .clk(clk), .rst_n(rst_n), .io_base(io_base), .io_we(io_we),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pad_in(pad_in), .latch_bits(latch_bits), .sync_lvl(sync_lvl),
    .data_hit(data_hit), .data_grp(data_grp)
  );

  gpio_grp_pad #(.NUM_GROUPS(NUM_GROUPS), .MODE_GROUPS(MODE_GROUPS)) u_pad (
    .oe_bits(oe_bits), .mode_bits(mode_bits), .latch_bits(latch_bits),
    .pad_oe(pad_oe), .pad_out(pad_out), .gpio_sel(gpio_sel)
  );
endmodule

// File: rtl/gpio_group_bank_chk.sv
module gpio_group_bank_chk #(
  parameter int unsigned NUM_GROUPS  = 8,
  parameter int unsigned MODE_GROUPS = 5,
  localparam int unsigned NPINS = NUM_GROUPS * 8,
  localparam int unsigned GRP_W = $clog2(NUM_GROUPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_we,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] oe_bits,
  input logic [NPINS-1:0] latch_bits,
  input logic [NPINS-1:0] sync_lvl,
  input logic             data_hit,
  input logic [GRP_W-1:0] data_grp
);
  function automatic logic [NPINS-1:0] fixed_mask();
    logic [NPINS-1:0] m = '0;
    for (int n = 0; n < NPINS; n++) m[n] = (n / 8) >= MODE_GROUPS;
    return m;
  endfunction
  localparam logic [NPINS-1:0] FIXED_MASK = fixed_mask();

  logic [1:0]       age;
  logic             wr_pend;
  logic [GRP_W-1:0] wr_grp;
  logic [7:0]       wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age     <= '0;
      wr_pend <= 1'b0;
      wr_grp  <= '0;
      wr_val  <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      wr_pend <= io_we && data_hit;
      wr_grp  <= data_grp;
      wr_val  <= io_wdata;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && latch_bits == '0));

  a_r5_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~oe_bits) == '0);

  a_r4_fixed_groups_follow_oe: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ oe_bits) & FIXED_MASK) == '0);

  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |-> latch_bits[wr_grp*8 +: 8] == wr_val);

  a_r7_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> sync_lvl == $past(pad_in, 2));

  a_r8_miss_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !data_hit |-> io_rdata == 8'hFF);

  a_r8_miss_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !data_hit) |=> $stable(latch_bits));
endmodule

bind gpio_group_bank gpio_group_bank_chk #(.NUM_GROUPS(NUM_GROUPS), .MODE_GROUPS(MODE_GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .pad_in(pad_in), .pad_oe(pad_oe), .oe_bits(oe_bits), .latch_bits(latch_bits),
  .sync_lvl(sync_lvl), .data_hit(data_hit), .data_grp(data_grp)
);

// File: tb/gpio_group_bank_bench.sv
module gpio_group_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;
  localparam int MG = 5;
  localparam int NP = NG * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_idx = '0, cfg_wdata = '0, cfg_rdata;
  logic io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, gpio_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_group_bank #(.NUM_GROUPS(NG), .MODE_GROUPS(MG)) u_gpio_group_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .gpio_sel(gpio_sel)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [NP-1:0] m_oe = '0, m_mode = '0, m_lat = '0, pad_q = '0;
  logic [15:0] m_base = '0;

  function automatic logic [7:0] exp_cfg(input logic [7:0] i);
    if (i == 8'h60) return m_base[15:8];
    if (i == 8'h61) return m_base[7:0];
    if (i >= 8'hC8 && i < 8'hC8 + NG) return m_oe[(i - 8'hC8) * 8 +: 8];
    if (i >= 8'hC0 && i < 8'hC0 + MG) return m_mode[(i - 8'hC0) * 8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_io(input logic [15:0] a);
    logic [15:0] off = a - m_base;
    if (off < 16'(NG)) return pad_q[off * 8 +: 8];
    return 8'hFF;
  endfunction

  function automatic logic [NP-1:0] exp_sel();
    logic [NP-1:0] s;
    for (int n = 0; n < NP; n++) s[n] = (n / 8 < MG) ? m_mode[n] : 1'b1;
    return s;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    return m_oe & exp_sel();
  endfunction

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] i, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (i == 8'h60) m_base[15:8] = v;
    if (i == 8'h61) m_base[7:0] = v;
    if (i >= 8'hC8 && i < 8'hC8 + NG) m_oe[(i - 8'hC8) * 8 +: 8] = v;
    if (i >= 8'hC0 && i < 8'hC0 + MG) m_mode[(i - 8'hC0) * 8 +: 8] = v;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] v);
    logic [15:0] off = a - m_base;
    @(negedge clk);
    io_we = 1'b1; io_addr = a; io_wdata = v;
    @(negedge clk);
    io_we = 1'b0;
    if (off < 16'(NG)) m_lat[off * 8 +: 8] = v;
  endtask

  task automatic cfg_read_chk(input string tag, input logic [7:0] i);
    cfg_idx = i; #1;
    chk(tag, NP'(cfg_rdata), NP'(exp_cfg(i)));
  endtask

  task automatic io_read_chk(input string tag, input logic [15:0] a);
    io_addr = a; #1;
    chk(tag, NP'(io_rdata), NP'(exp_io(a)));
  endtask

  task automatic check_pins(input string tag);
    #1;
    chk({tag, " R5 pad_oe"}, pad_oe, exp_oe());
    chk({tag, " R5 pad_out"}, pad_out, exp_oe() & m_lat);
    chk({tag, " R4 gpio_sel"}, gpio_sel, exp_sel());
  endtask

  task automatic set_pads(input logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (2) @(negedge clk);
    pad_q = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    pad_in = 64'hA5C3_0F96_1234_ABCD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    cfg_read_chk("R1 oe reg", 8'hC8);
    cfg_read_chk("R1 mode reg", 8'hC0);
    cfg_read_chk("R1 base hi", 8'h60);
    repeat (2) @(negedge clk);
    pad_q = pad_in;

    // R7: read returns pads, not latches, with a two-edge delay
    cfg_write(8'hC8, 8'hFF); cfg_write(8'hC0, 8'hFF);
    io_write(16'h0000, 8'h00);
    io_read_chk("R7 pad not latch", 16'h0000);
    @(negedge clk);
    pad_in = 64'h0000_0000_0000_005A;
    @(negedge clk); io_addr = 16'h0000; #1;
    chk("R7 after one edge", NP'(io_rdata), NP'(pad_q[7:0]));
    @(negedge clk); #1;
    chk("R7 after two edges", NP'(io_rdata), NP'(8'h5A));
    pad_q = pad_in;

    // R2: one pin through one lane
    cfg_write(8'hCB, 8'h10); cfg_write(8'hC3, 8'h10);
    io_write(16'h0003, 8'hFF);
    #1;
    chk("R2 pin 28 only", pad_out, (64'h1 << 28) | (exp_oe() & m_lat & ~(64'hFF << 24)));
    check_pins("R2");

    // R3 / R4: enable readback, group without mode byte
    cfg_write(8'hCE, 8'h81);
    cfg_read_chk("R3 oe readback", 8'hCE);
    cfg_write(8'hC6, 8'hFF);
    cfg_read_chk("R4 absent mode reads 0", 8'hC6);
    io_write(16'h0006, 8'h01);
    check_pins("R4 fixed group");
    #1;
    chk("R4 pin 48 driven", NP'(pad_out[48]), NP'(1'b1));

    // R6: whole byte replaced
    cfg_write(8'hC9, 8'hFF); cfg_write(8'hC1, 8'hFF);
    io_write(16'h0001, 8'hF0);
    io_write(16'h0001, 8'h01);
    #1;
    chk("R6 byte overwrite", NP'(pad_out[15:8]), NP'(8'h01));

    // R8: outside window
    io_write(16'h0000 + NG, 8'h5A);
    check_pins("R8 write ignored");
    io_read_chk("R8 above window", 16'h0000 + NG);
    io_read_chk("R8 below window", 16'hFFFF);

    // R9: relocation
    cfg_write(8'h60, 8'h0A); cfg_write(8'h61, 8'h20);
    cfg_read_chk("R9 base hi", 8'h60);
    cfg_read_chk("R9 base lo", 8'h61);
    io_write(16'h0A21, 8'h3C);
    check_pins("R9 relocated write");
    io_read_chk("R9 new window", 16'h0A20);
    io_read_chk("R9 old window gone", 16'h0000);

    // R10: unmapped index
    cfg_write(8'h12, 8'h77);
    cfg_read_chk("R10 unmapped", 8'h12);
    check_pins("R10 no side effect");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 4;
      case (op)
        0: begin
          int k = $urandom % 4;
          logic [7:0] idx;
          if (k == 0)      idx = 8'hC8 + 8'($urandom % NG);
          else if (k == 1) idx = 8'hC0 + 8'($urandom % 8);
          else if (k == 2) idx = ($urandom % 8 == 0) ? 8'h61 : 8'hC8;
          else             idx = 8'($urandom);
          cfg_write(idx, 8'($urandom));
        end
        1: io_write(m_base + 16'($urandom % (NG + 3)), 8'($urandom));
        2: set_pads({$urandom, $urandom});
        default: @(negedge clk);
      endcase
      check_pins("R5 random");
      cfg_read_chk("R3 random cfg read", 8'($urandom));
      io_read_chk("R7 random data read", m_base + 16'($urandom % (NG + 3)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule